// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a per-channel PWM command into the upper and lower switch enables of a synchronous buck half-bridge, for two independent channels. It never drives a switch on until the opposite switch is reported off. The upper enable waits for a flag saying the lower gate voltage has fallen below its threshold. The lower enable waits for a flag saying the phase node has fallen, or for a refresh timeout that keeps the bootstrap supply charged.

While the lower switch conducts, the block keeps watching the phase flag. If the phase node stays high for too long, reverse current is flowing, so the lower enable is dropped and the channel parks until the next high command. This makes the low side act like a diode. The command also has a third level, a shutdown window. If the command stays in that window long enough, both enables are forced low. A shared pair of supply comparator flags gates everything through a power-on reset with hysteresis.

All comparator flags and the command pass through two-flop synchronizers. All timeouts are counted in clock cycles.

Top module: `adaptive_gate_seq`

## Requirements
- R1: When the command goes high (code 00 = low, 01 = high, 1x = shutdown window), the lower enable drops first. The upper enable rises only after the lower-gate-low flag reads 1, and stays low for as long as that flag reads 0.
- R2: When the command goes low, the upper enable drops first. The lower enable rises on the third clock edge after the phase-low flag is set at the port, if that comes before the R3 timeout.
- R3: If the phase-low flag stays 0, the lower enable rises exactly REFRESH_CYC clock edges after the upper enable falls.
- R4: While the lower enable is on, it is dropped once the synchronized phase-low flag has read 0 for DIODE_CYC consecutive cycles. Any cycle with the flag at 1 restarts that count.
- R5: After a drop under R4, both enables stay low while the command stays low, even if the phase-low flag returns to 1. A high command resumes normal sequencing.
- R6: A command held in the shutdown window (code 10 or 11) for HOLDOFF_CYC consecutive synchronized cycles forces both enables low, and they stay low while the window persists. A shorter excursion into the window leaves the enables unchanged.
- R7: Once the command leaves the window, normal sequencing resumes. A high command follows R1 and a low command follows R2/R3.
- R8: Until the supply-above-rising flag has been seen, both enables stay low whatever the command.
- R9: The supply-below-falling flag forces both enables low. They stay low until the rising flag is seen again. With both supply flags at 0 the state is kept, and the falling flag wins when both are set.
- R10: The upper and lower enables of one channel are never high in the same cycle.
- R11: Each channel is sequenced only from its own command and flags. Activity on one channel does not change the other's enables.
- R12: During and right after reset, every enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwmCode | input | 2*NUM_CH | Per-channel command code, channel n in bits [2n+1:2n] |
| lgateLow | input | NUM_CH | Per-channel flag: lower gate voltage below threshold |
| phaseLow | input | NUM_CH | Per-channel flag: phase node below threshold |
| supplyAboveRise | input | 1 | Supply above the rising power-on threshold |
| supplyBelowFall | input | 1 | Supply below the falling power-on threshold |
| ugateEn | output | NUM_CH | Per-channel upper switch enable |
| lgateEn | output | NUM_CH | Per-channel lower switch enable |

## Verification
The hardest situation to reach is the diode-emulation count being restarted partway through. Doing so needs a phase-low pulse that lands a known number of cycles into the lower conduction window. The stimulus finds the rising edge of the lower enable at the port and places the pulse at a fixed offset from it. It then predicts the fall from the synchronizer depth, which makes the expected on-time an exact number. The same edge-relative timing drives a sweep of the phase-low arrival across the refresh window, and a sweep of shutdown-window excursion lengths around the holdoff.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HI_WAIT,
    ST_UPPER,
    ST_LO_WAIT,
    ST_LOWER,
    ST_PARK,
    ST_SHUT
  } seqState_t;

  typedef struct packed {
    logic timerClr;
    logic timerInc;
  } seqStrobe_t;

  localparam logic [1:0] CMD_LOW  = 2'b00;
  localparam logic [1:0] CMD_HIGH = 2'b01;

  function automatic logic cmdIsWindow(input logic [1:0] code);
    return code[1];
  endfunction

endpackage

// File: rtl/gseq_sync.sv
module gseq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/gseq_datapath.sv
module gseq_datapath
  import gseq_pkg::*;
#(
  parameter int REFRESH_CYC = 25,
  parameter int DIODE_CYC   = 200,
  parameter int HOLDOFF_CYC = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic [1:0] pwmS,
  output logic       refreshDone,
  output logic       diodeDone,
  output logic       holdoffDone
);
  localparam int TMR_MAX = (REFRESH_CYC > DIODE_CYC) ? REFRESH_CYC : DIODE_CYC;
  localparam int TW      = $clog2(TMR_MAX + 1);
  localparam int HW      = (HOLDOFF_CYC > 1) ? $clog2(HOLDOFF_CYC) : 1;
  localparam logic [TW-1:0] TMR_TOP     = TW'(TMR_MAX);
  localparam logic [TW-1:0] REFRESH_END = TW'(REFRESH_CYC - 1);
  localparam logic [TW-1:0] DIODE_END   = TW'(DIODE_CYC - 1);
  localparam logic [HW-1:0] HOLD_END    = HW'(HOLDOFF_CYC - 1);

  logic [TW-1:0] timer;
  logic [HW-1:0] holdCnt;
  logic          inWindow;

  assign inWindow = cmdIsWindow(pwmS);

  // Shared per-channel interval timer, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                timer <= '0;
    else if (strobe.timerClr)                 timer <= '0;
    else if (strobe.timerInc && timer != TMR_TOP) timer <= timer + 1'b1;
  end

  // Consecutive shutdown-window cycle counter, saturating at its end value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   holdCnt <= '0;
    else if (!inWindow)          holdCnt <= '0;
    else if (holdCnt != HOLD_END) holdCnt <= holdCnt + 1'b1;
  end

  assign refreshDone = (timer >= REFRESH_END);
  assign diodeDone   = (timer >= DIODE_END);
  assign holdoffDone = inWindow && (holdCnt == HOLD_END);

  generate
    if (HOLDOFF_CYC > 1) begin : g_holdChk
      assert_holdoff_run_R6: assert property (@(posedge clk) disable iff (!rstN)
        holdoffDone |-> $past(inWindow));
    end
  endgenerate
endmodule

// File: rtl/gseq_control.sv
module gseq_control
  import gseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic [1:0] pwmS,
  input  logic       lgateLowS,
  input  logic       phaseLowS,
  input  logic       refreshDone,
  input  logic       diodeDone,
  input  logic       holdoffDone,
  output seqStrobe_t strobe,
  output logic       ugate,
  output logic       lgate
);
  seqState_t state, nxt;
  logic cmdHigh, cmdWin;

  assign cmdHigh = (pwmS == CMD_HIGH);
  assign cmdWin  = cmdIsWindow(pwmS);

  always_comb begin
    nxt = state;
    if (!supplyOk) begin
      nxt = ST_IDLE;
    end else if (holdoffDone) begin
      nxt = ST_SHUT;
    end else if (!cmdWin) begin
      unique case (state)
        ST_IDLE, ST_SHUT: nxt = cmdHigh ? ST_HI_WAIT : ST_LO_WAIT;
        ST_HI_WAIT: begin
          if (!cmdHigh)       nxt = ST_LO_WAIT;
          else if (lgateLowS) nxt = ST_UPPER;
        end
        ST_UPPER: if (!cmdHigh) nxt = ST_LO_WAIT;
        ST_LO_WAIT: begin
          if (cmdHigh)                         nxt = ST_HI_WAIT;
          else if (phaseLowS || refreshDone)   nxt = ST_LOWER;
        end
        ST_LOWER: begin
          if (cmdHigh)                        nxt = ST_HI_WAIT;
          else if (!phaseLowS && diodeDone)   nxt = ST_PARK;
        end
        ST_PARK: if (cmdHigh) nxt = ST_HI_WAIT;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.timerInc = ((state == ST_LO_WAIT) && (nxt == ST_LO_WAIT)) ||
                      ((state == ST_LOWER) && (nxt == ST_LOWER) && !phaseLowS);
    strobe.timerClr = !strobe.timerInc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ugate <= 1'b0;
      lgate <= 1'b0;
    end else begin
      state <= nxt;
      ugate <= (nxt == ST_UPPER);
      lgate <= (nxt == ST_LOWER);
    end
  end

  assert_upper_after_lower_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ugate) |-> $past(lgateLowS) && !$past(lgate));
  assert_lower_after_phase_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lgate) |-> ($past(phaseLowS) || $past(refreshDone)) && !$past(ugate));
  assert_park_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PARK) && !cmdHigh |=> !lgate && !ugate);
  assert_shutdown_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    holdoffDone |=> !ugate && !lgate);
  assert_por_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> !ugate && !lgate);
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(ugate && lgate));
endmodule

// File: rtl/adaptive_gate_seq.sv
module adaptive_gate_seq
  import gseq_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int REFRESH_CYC = 25,
  parameter int DIODE_CYC   = 200,
  parameter int HOLDOFF_CYC = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2*NUM_CH-1:0]   pwmCode,
  input  logic [NUM_CH-1:0]     lgateLow,
  input  logic [NUM_CH-1:0]     phaseLow,
  input  logic                  supplyAboveRise,
  input  logic                  supplyBelowFall,
  output logic [NUM_CH-1:0]     ugateEn,
  output logic [NUM_CH-1:0]     lgateEn
);
  localparam int CH_IN_W = 4;

  logic [1:0] supS;
  logic       supplyOk;

  gseq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_supSync (
    .clk(clk), .rstN(rstN),
    .din({supplyBelowFall, supplyAboveRise}),
    .dout(supS)
  );

  // Power-on gate with hysteresis; falling flag has priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        supplyOk <= 1'b0;
    else if (supS[1]) supplyOk <= 1'b0;
    else if (supS[0]) supplyOk <= 1'b1;
  end

  assert_por_fall_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(supplyOk) |-> $past(supS[1]));
  assert_por_rise_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(supplyOk) |-> $past(supS[0]) && !$past(supS[1]));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      logic [CH_IN_W-1:0] chS;
      seqStrobe_t         strobe;
      logic refreshDone, diodeDone, holdoffDone;

      gseq_sync #(.WIDTH(CH_IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rstN(rstN),
        .din({phaseLow[gi], lgateLow[gi], pwmCode[2*gi +: 2]}),
        .dout(chS)
      );

      gseq_datapath #(
        .REFRESH_CYC(REFRESH_CYC), .DIODE_CYC(DIODE_CYC), .HOLDOFF_CYC(HOLDOFF_CYC)
      ) u_dp (
        .clk(clk), .rstN(rstN), .strobe(strobe), .pwmS(chS[1:0]),
        .refreshDone(refreshDone), .diodeDone(diodeDone), .holdoffDone(holdoffDone)
      );

      gseq_control u_ctl (
        .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .pwmS(chS[1:0]),
        .lgateLowS(chS[2]), .phaseLowS(chS[3]),
        .refreshDone(refreshDone), .diodeDone(diodeDone), .holdoffDone(holdoffDone),
        .strobe(strobe), .ugate(ugateEn[gi]), .lgate(lgateEn[gi])
      );
    end
  endgenerate
endmodule

// File: tb/adaptive_gate_seq_bench.sv
module adaptive_gate_seq_bench;
  localparam int NCH = 2;
  localparam int RC  = 6;
  localparam int DC  = 20;
  localparam int HC  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2*NCH-1:0] pwm = '0;
  logic [NCH-1:0] lgl = '0;
  logic [NCH-1:0] phl = '0;
  logic supR = 1'b0;
  logic supF = 1'b0;
  logic [NCH-1:0] ug, lg;

  int checks = 0;
  int fails = 0;
  int overlaps = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adaptive_gate_seq #(
    .NUM_CH(NCH), .SYNC_STAGES(2), .REFRESH_CYC(RC), .DIODE_CYC(DC), .HOLDOFF_CYC(HC)
  ) u_adaptive_gate_seq (
    .clk(clk), .rstN(rstN), .pwmCode(pwm), .lgateLow(lgl), .phaseLow(phl),
    .supplyAboveRise(supR), .supplyBelowFall(supF), .ugateEn(ug), .lgateEn(lg)
  );

  always @(negedge clk)
    if (rstN && ((ug[0] && lg[0]) || (ug[1] && lg[1]))) overlaps++;

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic setCmd(input int ch, input logic [1:0] c);
    pwm[2*ch +: 2] = c;
  endtask

  // wait until ch0 upper enable equals v; returns cycles waited
  task automatic waitUg0(input logic v, output int n);
    n = 0;
    while (ug[0] != v && n < 200) begin tick(); n++; end
  endtask

  task automatic waitLg0(input logic v, output int n);
    n = 0;
    while (lg[0] != v && n < 200) begin tick(); n++; end
  endtask

  initial begin
    int n, m;
    bit dropped, lgSeen;
    supF = 1'b1;
    tick(3);
    chk(ug == 0 && lg == 0, "R12 in reset", {ug, lg}, 0);
    rstN = 1'b1;
    supF = 1'b0;
    lgl = 2'b11;
    setCmd(0, 2'b01);
    setCmd(1, 2'b00);
    phl[1] = 1'b1;
    tick(1);
    chk(ug == 0 && lg == 0, "R12 after reset", {ug, lg}, 0);
    tick(10);
    chk(ug[0] == 0 && lg[1] == 0, "R8 no supply", {ug, lg}, 0);
    supR = 1'b1;
    tick(8);
    chk(ug[0] == 1, "R8 supply up ch0", ug[0], 1);
    chk(lg[1] == 1, "R2 ch1 lower on", lg[1], 1);

    // R9 hysteresis
    supR = 1'b0;
    tick(10);
    chk(ug[0] == 1, "R9 between thresholds keeps state", ug[0], 1);
    supF = 1'b1;
    tick(8);
    chk(ug == 0 && lg == 0, "R9 falling forces low", {ug, lg}, 0);
    supF = 1'b0;
    tick(10);
    chk(ug == 0 && lg == 0, "R9 stays low until rise", {ug, lg}, 0);
    supR = 1'b1; supF = 1'b1;
    tick(10);
    chk(ug == 0 && lg == 0, "R9 falling wins", {ug, lg}, 0);
    supF = 1'b0;
    tick(8);
    chk(ug[0] == 1 && lg[1] == 1, "R9 rise restores", {ug, lg}, 4'b0110);

    // R1: lower off first, upper waits for lower-gate-low flag
    phl[0] = 1'b1;
    setCmd(0, 2'b00);
    tick(10);
    chk(lg[0] == 1 && ug[0] == 0, "R2 ch0 lower on", {ug[0], lg[0]}, 1);
    lgl[0] = 1'b0;
    setCmd(0, 2'b01);
    tick(20);
    chk(ug[0] == 0 && lg[0] == 0, "R1 upper held while lower gate high", {ug[0], lg[0]}, 0);
    lgl[0] = 1'b1;
    tick(6);
    chk(ug[0] == 1, "R1 upper after flag", ug[0], 1);
    chk(lg[1] == 1 && ug[1] == 0, "R11 ch1 untouched", {ug[1], lg[1]}, 1);

    // R2/R3 sweep of phase-low arrival
    for (int d = 0; d <= RC + 2; d++) begin
      int expN;
      phl[0] = 1'b0;
      setCmd(0, 2'b01);
      tick(8);
      setCmd(0, 2'b00);
      waitUg0(1'b0, n);
      n = 0;
      while (lg[0] == 0 && n < 60) begin
        if (n == d) phl[0] = 1'b1;
        tick(); n++;
      end
      expN = (d + 3 < RC) ? d + 3 : RC;
      if (d + 3 < RC) chk(n == expN, "R2 phase-driven lower rise", n, expN);
      else            chk(n == expN, "R3 refresh timeout", n, expN);
    end

    // R4 diode emulation on-time, then R5 park
    phl[0] = 1'b0;
    setCmd(0, 2'b01);
    tick(8);
    setCmd(0, 2'b00);
    waitLg0(1'b1, n);
    m = 0;
    while (lg[0] == 1 && m < 400) begin tick(); m++; end
    chk(m == DC, "R4 lower on-time", m, DC);
    phl[0] = 1'b1;
    tick(12);
    chk(lg[0] == 0 && ug[0] == 0, "R5 park ignores phase low", {ug[0], lg[0]}, 0);
    setCmd(0, 2'b01);
    tick(8);
    chk(ug[0] == 1, "R5 high resumes", ug[0], 1);

    // R4 count restarted by a phase-low pulse
    phl[0] = 1'b0;
    tick(4);
    setCmd(0, 2'b00);
    waitLg0(1'b1, n);
    m = 0;
    while (lg[0] == 1 && m < 400) begin
      if (m == DC / 2) phl[0] = 1'b1;
      if (m == DC / 2 + 2) phl[0] = 1'b0;
      tick(); m++;
    end
    chk(m == DC / 2 + 4 + DC, "R4 restart on phase low", m, DC / 2 + 4 + DC);
    setCmd(0, 2'b01);
    tick(8);

    // R6 sweep of window excursion length
    for (int len = 1; len <= HC + 3; len++) begin
      dropped = 1'b0; lgSeen = 1'b0;
      setCmd(0, (len % 2) ? 2'b10 : 2'b11);
      for (int k = 0; k < len + 12; k++) begin
        if (k == len) setCmd(0, 2'b01);
        tick();
        if (ug[0] == 0) dropped = 1'b1;
        if (lg[0] == 1) lgSeen = 1'b1;
      end
      chk(dropped == (len >= HC) && !lgSeen, "R6 holdoff threshold", dropped, len >= HC);
      chk(ug[0] == 1, "R7 resume high after window", ug[0], 1);
    end

    // R6 sustained window, R7 exit to low
    setCmd(0, 2'b10);
    tick(HC + 8);
    chk(ug[0] == 0 && lg[0] == 0, "R6 held low in window", {ug[0], lg[0]}, 0);
    phl[0] = 1'b1;
    setCmd(0, 2'b00);
    tick(8);
    chk(lg[0] == 1, "R7 exit to low path", lg[0], 1);

    // R11: ch1 shutdown while ch0 active
    setCmd(0, 2'b01);
    tick(8);
    setCmd(1, 2'b10);
    tick(HC + 8);
    chk(ug[1] == 0 && lg[1] == 0, "R11 ch1 shut", {ug[1], lg[1]}, 0);
    chk(ug[0] == 1 && lg[0] == 0, "R11 ch0 unaffected", {ug[0], lg[0]}, 2);
    setCmd(1, 2'b00);
    tick(8);
    chk(lg[1] == 1, "R11 ch1 back", lg[1], 1);

    chk(overlaps == 0, "R10 no overlap", overlaps, 0);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end
endmodule